// File: doc/BRIEF.md
# Scatter-Gather Bus-Master Storage DMA Channel

This block is the data mover of one disk-style storage channel. Software programs it through a small register bus: a pointer to a table of region descriptors held in memory, a command byte holding a go bit and a direction bit, and a status byte. Once the go bit is set, the channel fetches descriptors one at a time, and for each region moves 32-bit words between memory and the device. Each word is paired with a device data request. When the region marked as the last one is used up, the channel drops its active flag and waits for software.

The device signals the end of its command on a separate completion input. That input sets the interrupt flag, which also drives the irq output. When software clears the go bit, the channel reports a one-byte end code. The code is zero only for a clean finish; otherwise it carries the raw status. A command watchdog, armed by the go bit, judges the status each time its programmable period expires. It either waits once more, reports a failure, or asks for a bus reset.

Top module: `sgdma_chan`

## Requirements
- R1: After reset, the command, status and pointer registers all read zero, and irq, mem_req and dev_ack are low.
- R2: Register address 0 is the command byte: bit 0 is go and bit 3 is direction (1 = device words are written to memory, 0 = memory words are read for the device). All its other bits read zero. Address 2 is the 32-bit descriptor table pointer and reads back what was written.
- R3: Status bits 3 to 6 are plain read/write storage, with bits 5 and 6 serving as the drive 0 and drive 1 DMA-capable flags. Status bit 7 always reads zero. A status write never sets bits 0, 1 or 2.
- R4: Status bit 1 (error) and bit 2 (interrupt) are cleared by writing 1 to them. Writing 0 to them leaves them unchanged.
- R5: Status bit 0 (active) sets when go changes from 0 to 1. It clears when the last region is used up, on a memory error, or when go is written to 0.
- R6: Each descriptor is two words at the pointer, then at pointer+8 and so on. Word 0 is the region byte address. In word 1, bits 15:0 are the byte count (0 means 65536) and bit 31 marks the last region. One word moves per 4 bytes, at rising addresses, and nothing past the last region is touched.
- R7: With direction 1, each word the device offers on dev_req is acknowledged and then written to memory. With direction 0, each word is read from memory and given to the device on dev_rdata with dev_ack.
- R8: While go is 0, a pending dev_req gets no dev_ack and causes no memory access. The transfer proceeds once go is set.
- R9: A memory response with mem_err sets the error flag, clears active and ends the walk without further accesses.
- R10: A dev_done pulse sets the interrupt flag, and irq equals that flag.
- R11: Writing go from 1 to 0 pulses end_valid with end_code = 0 when status bits 2:0 read 100, and with end_code = 0x10 OR the status byte otherwise.
- R12: The watchdog period, counted from the go write, is cmd_timeout cycles. At expiry, with the error flag set, it raises wd_fail. With active, error and interrupt all clear, it raises wd_bus_reset.
- R13: At expiry, with status bits 3 and 4 both set, the watchdog waits one more period without using its single extra period. Otherwise, with active or interrupt set, it uses the extra period once. Any expiry after the extra period has been used raises wd_fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 command, 1 status, 2 pointer) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| cmd_timeout | input | TMO_W | Watchdog period in cycles |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory response strobe |
| mem_err | input | 1 | Memory response is an error |
| mem_rdata | input | 32 | Memory read data |
| dev_req | input | 1 | Device requests a data word |
| dev_ack | output | 1 | Word accepted from or given to the device |
| dev_wdata | input | 32 | Word from the device |
| dev_rdata | output | 32 | Word to the device |
| dev_done | input | 1 | Device command completion |
| irq | output | 1 | Interrupt, follows status bit 2 |
| end_valid | output | 1 | End report strobe on a stop write |
| end_code | output | 8 | End report value |
| wd_fail | output | 1 | Watchdog failure verdict |
| wd_bus_reset | output | 1 | Watchdog bus reset request |

## Verification
The hardest state to reach is the watchdog's second expiry, because it needs a transfer that stays open across two full periods while the status holds a chosen pattern. The bench holds dev_req low so the channel stays active with go set. It presets status bits 3 and 4 to show the free re-arm, then clears them to force the single extra period and the failure after it. It also provokes an error verdict by mapping a memory error onto the first data word, and a bus-reset verdict by finishing a short transfer without any device completion. Descriptor walking is swept over every region length from 4 to 64 bytes in both directions, plus a three-region chain and a 65536-byte region.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
    localparam int LEN_W      = 16;
    localparam int WORD_BYTES = 4;
    localparam int DESC_BYTES = 8;

    localparam logic [1:0] RA_CMD = 2'd0;
    localparam logic [1:0] RA_STA = 2'd1;
    localparam logic [1:0] RA_PTR = 2'd2;

    localparam int CMD_GO    = 0;
    localparam int CMD_TOMEM = 3;
    localparam int ST_ACT    = 0;
    localparam int ST_ERR    = 1;
    localparam int ST_INT    = 2;
    localparam int ST_AUX0   = 3;
    localparam int ST_AUX1   = 4;
    localparam int PRD_LAST  = 31;

    typedef enum logic [2:0] {
        W_IDLE, W_DESC0, W_DESC1, W_XFER, W_MEMRD, W_MEMWR
    } walk_st_t;

    typedef struct packed {
        logic [1:0] cap;
        logic [1:0] aux;
        logic       intr;
        logic       err;
        logic       act;
    } sta_t;

    typedef struct packed {
        logic [31:0]    addr;
        logic [LEN_W:0] left;
        logic           last;
    } region_t;

    typedef enum logic [2:0] {
        WD_FREE, WD_RIDE, WD_FAIL, WD_RESET
    } wd_verdict_t;

    function automatic logic [LEN_W:0] region_bytes(input logic [LEN_W-1:0] n);
        return (n == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, n};
    endfunction

    function automatic logic [7:0] end_report(input logic [7:0] s);
        return (s[2:0] == 3'b100) ? 8'h00 : (8'h10 | s);
    endfunction

    function automatic wd_verdict_t wd_judge(input logic [7:0] s, input logic ride_used);
        if (ride_used)                   return WD_FAIL;
        if (s[ST_AUX0] && s[ST_AUX1])    return WD_FREE;
        if (s[ST_ERR])                   return WD_FAIL;
        if (s[ST_ACT] || s[ST_INT])      return WD_RIDE;
        return WD_RESET;
    endfunction
endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
    import sgdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        fin,
    input  logic        fault,
    input  logic        dev_done,
    output logic        start,
    output logic        start_rise,
    output logic        dir,
    output logic [31:0] tbl_ptr,
    output logic [7:0]  sta,
    output logic        end_valid,
    output logic [7:0]  end_code
);
    logic  go_q, dir_q;
    logic [31:0] ptr_q;
    sta_t  st;
    logic  wr_cmd, wr_sta, wr_ptr, stop;

    assign wr_cmd     = reg_wr && (reg_addr == RA_CMD);
    assign wr_sta     = reg_wr && (reg_addr == RA_STA);
    assign wr_ptr     = reg_wr && (reg_addr == RA_PTR);
    assign start_rise = wr_cmd && reg_wdata[CMD_GO] && !go_q;
    assign stop       = wr_cmd && !reg_wdata[CMD_GO] && go_q;

    assign start     = go_q;
    assign dir       = dir_q;
    assign tbl_ptr   = ptr_q;
    assign sta       = {1'b0, st};
    assign end_valid = stop;
    assign end_code  = end_report(sta);

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q  <= 1'b0;
            dir_q <= 1'b0;
            ptr_q <= '0;
            st    <= '0;
        end else begin
            if (wr_cmd) begin
                go_q  <= reg_wdata[CMD_GO];
                dir_q <= reg_wdata[CMD_TOMEM];
            end
            if (wr_ptr) ptr_q <= reg_wdata;
            if (wr_sta) begin
                st.aux <= reg_wdata[4:3];
                st.cap <= reg_wdata[6:5];
            end
            if (start_rise)                 st.act <= 1'b1;
            else if (fin || fault || stop)  st.act <= 1'b0;
            if (fault)                             st.err <= 1'b1;
            else if (wr_sta && reg_wdata[ST_ERR])  st.err <= 1'b0;
            if (dev_done)                          st.intr <= 1'b1;
            else if (wr_sta && reg_wdata[ST_INT])  st.intr <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CMD:  reg_rdata = {28'b0, dir_q, 2'b0, go_q};
            RA_STA:  reg_rdata = {24'b0, sta};
            RA_PTR:  reg_rdata = ptr_q;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sgdma_walker.sv
module sgdma_walker
    import sgdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        start_rise,
    input  logic        dir,
    input  logic [31:0] tbl_ptr,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic        mem_err,
    input  logic [31:0] mem_rdata,
    input  logic        dev_req,
    output logic        dev_ack,
    input  logic [31:0] dev_wdata,
    output logic [31:0] dev_rdata,
    output logic        fin,
    output logic        fault
);
    localparam logic [LEN_W:0] STEP = (LEN_W+1)'(WORD_BYTES);

    walk_st_t    state;
    logic [31:0] desc_ptr;
    region_t     cur;
    logic [31:0] wbuf;
    logic        in_mem, in_data, last_word, ok_ack;

    assign in_data   = (state == W_MEMRD) || (state == W_MEMWR);
    assign in_mem    = in_data || (state == W_DESC0) || (state == W_DESC1);
    assign last_word = (cur.left <= STEP);
    assign ok_ack    = mem_ack && !mem_err;

    assign mem_req   = start && in_mem;
    assign mem_we    = (state == W_MEMWR);
    assign mem_wdata = wbuf;
    assign dev_rdata = mem_rdata;
    assign dev_ack   = start && (((state == W_XFER) && dev_req && dir) ||
                                 ((state == W_MEMRD) && ok_ack));
    assign fault     = mem_req && mem_ack && mem_err;
    assign fin       = start && in_data && ok_ack && last_word && cur.last;

    always_comb begin
        case (state)
            W_DESC0: mem_addr = desc_ptr;
            W_DESC1: mem_addr = desc_ptr + 32'(WORD_BYTES);
            default: mem_addr = cur.addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= W_IDLE;
            desc_ptr <= '0;
            cur      <= '0;
            wbuf     <= '0;
        end else if (state != W_IDLE && !start) begin
            state <= W_IDLE;
        end else begin
            case (state)
                W_IDLE: if (start_rise) begin
                    desc_ptr <= tbl_ptr;
                    state    <= W_DESC0;
                end
                W_DESC0: if (mem_ack) begin
                    if (mem_err) state <= W_IDLE;
                    else begin
                        cur.addr <= {mem_rdata[31:2], 2'b00};
                        state    <= W_DESC1;
                    end
                end
                W_DESC1: if (mem_ack) begin
                    if (mem_err) state <= W_IDLE;
                    else begin
                        cur.left <= region_bytes(mem_rdata[LEN_W-1:0]);
                        cur.last <= mem_rdata[PRD_LAST];
                        state    <= W_XFER;
                    end
                end
                W_XFER: if (dev_req) begin
                    if (dir) begin
                        wbuf  <= dev_wdata;
                        state <= W_MEMWR;
                    end else begin
                        state <= W_MEMRD;
                    end
                end
                W_MEMRD, W_MEMWR: if (mem_ack) begin
                    if (mem_err) state <= W_IDLE;
                    else begin
                        cur.addr <= cur.addr + 32'(WORD_BYTES);
                        cur.left <= cur.left - STEP;
                        if (!last_word)    state <= W_XFER;
                        else if (cur.last) state <= W_IDLE;
                        else begin
                            desc_ptr <= desc_ptr + 32'(DESC_BYTES);
                            state    <= W_DESC0;
                        end
                    end
                end
                default: state <= W_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sgdma_wdog.sv
module sgdma_wdog
    import sgdma_pkg::*;
#(
    parameter int TMO_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             start_rise,
    input  logic [7:0]       sta,
    input  logic [TMO_W-1:0] cmd_timeout,
    output logic             wd_fail,
    output logic             wd_bus_reset
);
    logic             armed, ride_used, expire;
    logic [TMO_W-1:0] cnt;
    wd_verdict_t      verdict;

    assign expire       = armed && (({1'b0, cnt} + 1'b1) >= {1'b0, cmd_timeout});
    assign verdict      = wd_judge(sta, ride_used);
    assign wd_fail      = expire && (verdict == WD_FAIL);
    assign wd_bus_reset = expire && (verdict == WD_RESET);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed     <= 1'b0;
            ride_used <= 1'b0;
            cnt       <= '0;
        end else if (start_rise) begin
            armed     <= 1'b1;
            ride_used <= 1'b0;
            cnt       <= '0;
        end else if (!start) begin
            armed <= 1'b0;
        end else if (expire) begin
            cnt <= '0;
            if (verdict == WD_FAIL || verdict == WD_RESET) armed <= 1'b0;
            if (verdict == WD_RIDE) ride_used <= 1'b1;
        end else if (armed) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sgdma_chan.sv
module sgdma_chan
    import sgdma_pkg::*;
#(
    parameter int TMO_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [TMO_W-1:0] cmd_timeout,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic             mem_err,
    input  logic [31:0]      mem_rdata,
    input  logic             dev_req,
    output logic             dev_ack,
    input  logic [31:0]      dev_wdata,
    output logic [31:0]      dev_rdata,
    input  logic             dev_done,
    output logic             irq,
    output logic             end_valid,
    output logic [7:0]       end_code,
    output logic             wd_fail,
    output logic             wd_bus_reset
);
    logic        w_start, w_start_rise, w_dir, w_fin, w_fault;
    logic [31:0] w_ptr;
    logic [7:0]  w_sta;

    sgdma_regs u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fin(w_fin),
        .fault(w_fault), .dev_done(dev_done), .start(w_start),
        .start_rise(w_start_rise), .dir(w_dir), .tbl_ptr(w_ptr),
        .sta(w_sta), .end_valid(end_valid), .end_code(end_code)
    );

    sgdma_walker u_walk (
        .clk(clk), .rst(rst), .start(w_start), .start_rise(w_start_rise),
        .dir(w_dir), .tbl_ptr(w_ptr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_err(mem_err), .mem_rdata(mem_rdata), .dev_req(dev_req),
        .dev_ack(dev_ack), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
        .fin(w_fin), .fault(w_fault)
    );

    sgdma_wdog #(.TMO_W(TMO_W)) u_wdog (
        .clk(clk), .rst(rst), .start(w_start), .start_rise(w_start_rise),
        .sta(w_sta), .cmd_timeout(cmd_timeout), .wd_fail(wd_fail),
        .wd_bus_reset(wd_bus_reset)
    );

    assign irq = w_sta[ST_INT];
endmodule

// File: rtl/sgdma_chan_chk.sv
module sgdma_chan_chk
    import sgdma_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        start_rise,
    input logic        fin,
    input logic        fault,
    input logic [7:0]  sta,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        dev_ack,
    input logic        mem_req,
    input logic        dev_done,
    input logic        irq,
    input logic        end_valid,
    input logic [7:0]  end_code,
    input logic        wd_fail,
    input logic        wd_bus_reset
);
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        !start |-> (!dev_ack && !mem_req));                                   // R8
    AST_ACT_SET: assert property (@(posedge clk) disable iff (rst)
        start_rise |=> sta[ST_ACT]);                                          // R5
    AST_ACT_DROP: assert property (@(posedge clk) disable iff (rst)
        (fin || fault) |=> !sta[ST_ACT]);                                     // R5
    AST_FAULT_ERR: assert property (@(posedge clk) disable iff (rst)
        fault |=> sta[ST_ERR]);                                               // R9
    AST_DONE_IRQ: assert property (@(posedge clk) disable iff (rst)
        dev_done |=> irq);                                                    // R10
    AST_ERR_W1C: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == RA_STA && reg_wdata[ST_ERR] && !fault) |=> !sta[ST_ERR]); // R4
    AST_GOOD_END: assert property (@(posedge clk) disable iff (rst)
        (end_valid && end_code == 8'h00) |-> (sta[2:0] == 3'b100));           // R11
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        !(wd_fail && wd_bus_reset));                                          // R12
    AST_BIT7_ZERO: assert property (@(posedge clk) disable iff (rst)
        !sta[7]);                                                             // R3
endmodule

bind sgdma_chan sgdma_chan_chk u_chk (
    .clk(clk), .rst(rst), .start(w_start), .start_rise(w_start_rise),
    .fin(w_fin), .fault(w_fault), .sta(w_sta), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .dev_ack(dev_ack),
    .mem_req(mem_req), .dev_done(dev_done), .irq(irq),
    .end_valid(end_valid), .end_code(end_code), .wd_fail(wd_fail),
    .wd_bus_reset(wd_bus_reset)
);

// File: tb/sim_sgdma_chan.sv
`timescale 1ns/1ps
module sim_sgdma_chan;
    localparam int CLK_P = 10;
    localparam int TMO_W = 20;

    logic clk = 0, rst = 1;
    logic reg_wr = 0;
    logic [1:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic [TMO_W-1:0] cmd_timeout = '1;
    logic mem_req, mem_we, mem_ack, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic dev_req = 0, dev_ack, dev_done = 0;
    logic [31:0] dev_wdata, dev_rdata;
    logic irq, end_valid, wd_fail, wd_bus_reset;
    logic [7:0] end_code;

    int n_chk = 0, n_fail = 0;
    logic [31:0] mem [0:1023];
    logic [31:0] rx  [0:1023];
    logic [31:0] dev_cnt;
    int end_cnt;
    logic [7:0] end_last;
    logic err_en = 0;
    logic [31:0] err_addr = 0;

    always #(CLK_P/2) clk = ~clk;

    sgdma_chan #(.TMO_W(TMO_W)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_timeout(cmd_timeout),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .dev_req(dev_req), .dev_ack(dev_ack),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_done(dev_done),
        .irq(irq), .end_valid(end_valid), .end_code(end_code),
        .wd_fail(wd_fail), .wd_bus_reset(wd_bus_reset)
    );

    function automatic logic [31:0] pat(input logic [31:0] k);
        return 32'hC0DE_0000 ^ (k * 32'd9);
    endfunction

    function automatic logic [31:0] rdpat(input int n, input int i);
        return 32'h1000_0000 + n * 256 + i;
    endfunction

    assign dev_wdata = pat(dev_cnt);

    // memory model: one-cycle response, error mapped on one address
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 0; mem_err <= 0; mem_rdata <= 0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            mem_err <= mem_req && !mem_ack && err_en && (mem_addr == err_addr);
            if (mem_req && !mem_ack) begin
                mem_rdata <= mem[mem_addr[11:2]];
                if (mem_we && !(err_en && mem_addr == err_addr))
                    mem[mem_addr[11:2]] <= mem_wdata;
            end
        end
    end

    // device model and end-report monitor
    always @(posedge clk) begin
        if (rst) begin
            dev_cnt <= 0; end_cnt <= 0; end_last <= 0;
        end else begin
            if (dev_ack) begin
                dev_cnt <= dev_cnt + 1;
                rx[dev_cnt[9:0]] <= dev_rdata;
            end
            if (end_valid) begin
                end_cnt  <= end_cnt + 1;
                end_last <= end_code;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic wait_inactive(input int lim);
        logic [31:0] s;
        for (int i = 0; i < lim; i++) begin
            rd(2'd1, s);
            if (!s[0]) break;
        end
    endtask

    task automatic pulse_done;
        @(negedge clk); dev_done = 1;
        @(negedge clk); dev_done = 0;
    endtask

    task automatic stop_clear;
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h06);
    endtask

    // called right after the go write: first sample is one cycle after it
    task automatic measure(input int lim, output int k, output logic f, output logic r);
        k = 0; f = 0; r = 0;
        for (int i = 1; i <= lim; i++) begin
            if (wd_fail || wd_bus_reset) begin
                k = i; f = wd_fail; r = wd_bus_reset; break;
            end
            @(negedge clk);
        end
    endtask

    task automatic set_desc(input int idx, input logic [31:0] a, input logic [31:0] w1);
        mem[idx] <= a; mem[idx+1] <= w1;
    endtask

    initial begin
        logic [31:0] v, base;
        int ec, k;
        logic f, r, saw;

        repeat (3) @(negedge clk);
        rst = 0;

        // reset state
        rd(2'd0, v); chk("R1 cmd", v, 0);
        rd(2'd1, v); chk("R1 status", v, 0);
        rd(2'd2, v); chk("R1 ptr", v, 0);
        chk("R1 irq", irq, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 dev_ack", dev_ack, 0);

        // register map
        wr(2'd2, 32'h1234_5678); rd(2'd2, v); chk("R2 ptr readback", v, 32'h1234_5678);
        wr(2'd0, 32'h08); rd(2'd0, v); chk("R2 cmd dir", v, 32'h08);
        wr(2'd0, 32'hF6); rd(2'd0, v); chk("R2 cmd unused bits", v, 32'h00);
        wr(2'd1, 32'h78); rd(2'd1, v); chk("R3 rw bits", v, 32'h78);
        wr(2'd1, 32'hFF); rd(2'd1, v); chk("R3 bit7 and flags", v, 32'h78);
        chk("R3 no irq from write", irq, 0);
        wr(2'd1, 32'h00); rd(2'd1, v); chk("R3 cleared", v, 32'h00);

        // single-region sweep, both directions
        for (int d = 0; d < 2; d++) begin
            for (int n = 1; n <= 16; n++) begin
                set_desc(32'h300, 32'h100, 32'h8000_0000 | (n * 4));
                for (int i = 0; i <= 16; i++)
                    mem[32'h40 + i] <= (d != 0) ? 32'hDEAD_BEEF : rdpat(n, i);
                base = dev_cnt; ec = end_cnt;
                wr(2'd2, 32'hC00);
                dev_req = 1;
                wr(2'd0, (d << 3) | 1);
                rd(2'd1, v); chk("R5 active after go", v[0], 1);
                wait_inactive(2000);
                dev_req = 0;
                rd(2'd1, v); chk("R5 active drops at last region", v[2:0], 3'b000);
                pulse_done;
                chk("R10 irq after done", irq, 1);
                wr(2'd0, d << 3);
                chk("R11 one end report", end_cnt, ec + 1);
                chk("R11 good end code", end_last, 8'h00);
                chk("R6 word count", dev_cnt - base, n);
                for (int i = 0; i < n; i++) begin
                    if (d != 0) chk("R7 to-memory data", mem[32'h40 + i], pat(base + i));
                    else        chk("R7 from-memory data", rx[(base + i) % 1024], rdpat(n, i));
                end
                if (d != 0) chk("R6 no write past region", mem[32'h40 + n], 32'hDEAD_BEEF);
                wr(2'd1, 32'h06);
                rd(2'd1, v); chk("R4 flags cleared", v, 0);
            end
        end

        // three-region chain with a fourth entry that must stay untouched
        set_desc(32'h300, 32'h200, 32'd8);
        set_desc(32'h302, 32'h280, 32'd12);
        set_desc(32'h304, 32'h400, 32'h8000_0004);
        set_desc(32'h306, 32'h500, 32'h8000_0004);
        mem[32'h82] <= 32'hDEAD_BEEF; mem[32'hA3] <= 32'hDEAD_BEEF;
        mem[32'h101] <= 32'hDEAD_BEEF; mem[32'h140] <= 32'hDEAD_BEEF;
        base = dev_cnt;
        wr(2'd2, 32'hC00); dev_req = 1; wr(2'd0, 32'h09);
        wait_inactive(2000); dev_req = 0;
        chk("R6 chain word count", dev_cnt - base, 6);
        chk("R6 chain r0w0", mem[32'h80], pat(base));
        chk("R6 chain r0w1", mem[32'h81], pat(base + 1));
        chk("R6 chain r1w0", mem[32'hA0], pat(base + 2));
        chk("R6 chain r1w2", mem[32'hA2], pat(base + 4));
        chk("R6 chain r2w0", mem[32'h100], pat(base + 5));
        chk("R6 chain gap0", mem[32'h82], 32'hDEAD_BEEF);
        chk("R6 chain gap1", mem[32'hA3], 32'hDEAD_BEEF);
        chk("R6 chain stops at last", mem[32'h140], 32'hDEAD_BEEF);
        stop_clear;

        // held-off device request before go
        set_desc(32'h300, 32'h100, 32'h8000_0008);
        base = dev_cnt;
        wr(2'd2, 32'hC00); wr(2'd0, 32'h08);
        dev_req = 1; saw = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); saw = saw | dev_ack | mem_req;
        end
        chk("R8 no ack or access before go", saw, 0);
        chk("R8 no words before go", dev_cnt - base, 0);
        wr(2'd0, 32'h09);
        wait_inactive(2000); dev_req = 0;
        chk("R8 transfer after go", dev_cnt - base, 2);
        stop_clear;

        // memory error on second data word
        set_desc(32'h300, 32'h100, 32'h8000_0010);
        mem[32'h41] <= 32'hDEAD_BEEF;
        err_en = 1; err_addr = 32'h104;
        base = dev_cnt;
        wr(2'd2, 32'hC00); dev_req = 1; wr(2'd0, 32'h09);
        wait_inactive(2000); dev_req = 0;
        repeat (5) @(negedge clk);
        rd(2'd1, v); chk("R9 error status", v, 32'h02);
        chk("R9 words before stop", dev_cnt - base, 2);
        chk("R9 failed word not stored", mem[32'h41], 32'hDEAD_BEEF);
        wr(2'd0, 32'h08);
        chk("R11 error end code", end_last, 8'h12);
        err_en = 0;
        wr(2'd1, 32'h04); rd(2'd1, v); chk("R4 zero leaves error", v, 32'h02);
        wr(2'd1, 32'h02); rd(2'd1, v); chk("R4 error cleared", v, 32'h00);
        pulse_done;
        rd(2'd1, v); chk("R10 intr flag", v, 32'h04);
        chk("R10 irq follows", irq, 1);
        wr(2'd1, 32'h02); rd(2'd1, v); chk("R4 zero leaves intr", v, 32'h04);
        wr(2'd1, 32'h04); rd(2'd1, v); chk("R4 intr cleared", v, 32'h00);
        chk("R10 irq low", irq, 0);

        // watchdog
        cmd_timeout = 20;
        set_desc(32'h300, 32'h100, 32'h8000_0004);
        wr(2'd2, 32'hC00); dev_req = 1; wr(2'd0, 32'h09);
        measure(200, k, f, r); dev_req = 0;
        chk("R12 bus reset time", k, 20);
        chk("R12 bus reset verdict", {f, r}, 2'b01);
        stop_clear;

        wr(2'd0, 32'h09);
        measure(200, k, f, r);
        chk("R13 fail after extra period", k, 40);
        chk("R13 fail verdict", {f, r}, 2'b10);
        wr(2'd0, 32'h08);
        chk("R11 stopped while active", end_last, 8'h11);
        stop_clear;

        wr(2'd1, 32'h18); wr(2'd0, 32'h09);
        measure(100, k, f, r);
        chk("R13 busy pattern re-arms freely", k, 0);
        wr(2'd1, 32'h00);
        measure(100, k, f, r);
        chk("R13 extra period then fail", {f, r}, 2'b10);
        stop_clear;

        err_en = 1; err_addr = 32'h100;
        set_desc(32'h300, 32'h100, 32'h8000_0008);
        wr(2'd2, 32'hC00); dev_req = 1; wr(2'd0, 32'h09);
        measure(200, k, f, r); dev_req = 0;
        chk("R12 error verdict time", k, 20);
        chk("R12 error verdict", {f, r}, 2'b10);
        err_en = 0;
        stop_clear;
        cmd_timeout = '1;

        // 65536-byte region
        set_desc(32'h300, 32'h100, 32'h8000_0000);
        base = dev_cnt;
        wr(2'd2, 32'hC00); dev_req = 1; wr(2'd0, 32'h09);
        wait_inactive(70000); dev_req = 0;
        chk("R6 zero count is 65536 bytes", dev_cnt - base, 16384);
        rd(2'd1, v); chk("R5 idle after long region", v[0], 0);
        stop_clear;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule